// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one synchronous DRAM burst. A start strobe captures a start column, a write/read indication and the mode register word. From that point the block presents one column per beat. Each pulse of the advance input moves it to the next beat. The address order follows the burst type held in the mode word. Sequential bursts wrap inside the block of columns that is aligned to the burst length. Interleaved bursts XOR the beat number into the low start bits. A full-page burst walks through every column and wraps until a stop input ends it.

A last-beat flag marks the final beat of a finite burst, and a busy flag is high while a burst is in progress. Under the single-write option, a write burst always lasts one beat whatever length is programmed. Read bursts are not affected by that option. Command sequencing, bank tracking and the data path sit outside this block.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, busy and lastBeat are 0.
- R2: When start is sampled high, the next cycle shows col equal to the sampled startCol and busy at 1. This also holds when start arrives during a burst, which restarts the burst.
- R3: modeWord bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4 and 011 gives 8. The codes 100, 101 and 110 act as length 1. Bits 8:4 and 11:10 have no effect.
- R4: With modeWord bit 3 at 0 (sequential), beat k shows the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay fixed.
- R5: With modeWord bit 3 at 1 (interleaved), beat k shows the start column with its low log2(BL) bits XORed with k.
- R6: While busy is high and advance, start and stop are all low, col holds its value.
- R7: lastBeat is high exactly on beat BL-1 of a finite burst. An advance on that beat drops busy in the next cycle.
- R8: Code 111 selects full page. Beat k shows (start + k) mod 256, bit 3 has no effect, lastBeat stays 0, and busy stays 1 through any number of advances.
- R9: Stop sampled high without start drops busy in the next cycle, for any burst type. If start and stop are both high, start wins.
- R10: With modeWord bit 9 at 1, a burst started with isWrite high lasts one beat. A read burst, or a write burst with bit 9 at 0, keeps the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| modeWord | input | 12 | Mode register word, sampled at start |
| startCol | input | 8 | First column of the burst, sampled at start |
| isWrite | input | 1 | High when the burst is a write, sampled at start |
| start | input | 1 | Begin a burst |
| advance | input | 1 | Move to the next beat |
| stop | input | 1 | End the current burst |
| col | output | 8 | Column address of the current beat |
| lastBeat | output | 1 | Current beat is the final one of a finite burst |
| busy | output | 1 | A burst is in progress |

## Verification
The bench sweeps every start column for each finite length under both burst types. This covers start columns that are not aligned to the burst. A design that carried the sequential wrap into the upper bits, or that added where it should XOR, would give wrong addresses on those beats. A full-page burst is run across the 255-to-0 boundary with the interleave bit set. That run catches a design that raises lastBeat, stops itself or honours the interleave bit in full page. Other tests cover the single-write option for both read and write bursts, reserved length codes, stalls between beats, stop in the middle of a burst, and a restart while busy. A design that got any of these wrong would keep a stale length, drift while stalled or stay busy.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int MODE_W      = 12;
  localparam int LEN_LSB     = 0;
  localparam int TYPE_BIT    = 3;
  localparam int SINGLE_WBIT = 9;

  typedef struct packed {
    logic load;
    logic step;
  } colStrobes_t;

  // Beat-index mask for a length code; full page returns all ones
  function automatic logic [7:0] lenMask(input logic [2:0] code);
    case (code)
      3'b001:  lenMask = 8'd1;
      3'b010:  lenMask = 8'd3;
      3'b011:  lenMask = 8'd7;
      3'b111:  lenMask = 8'hFF;
      default: lenMask = 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  colStrobes_t       strobes,
  input  logic [MODE_W-1:0] modeWord,
  input  logic [COL_W-1:0]  startCol,
  input  logic              isWrite,
  output logic [COL_W-1:0]  col,
  output logic              atEnd,
  output logic              fullPage
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic [COL_W-1:0] startReg, cntReg, maskReg;
  logic             ilvReg, fpReg;
  logic [2:0]       lenCode;
  logic             singleWr, fpNext;
  logic [COL_W-1:0] maskNext, lowSeq, lowIlv, lowSel;

  always_comb begin
    lenCode  = modeWord[LEN_LSB +: 3];
    singleWr = modeWord[SINGLE_WBIT] & isWrite;
    fpNext   = (lenCode == 3'b111) && !singleWr;
    if (singleWr)    maskNext = '0;
    else if (fpNext) maskNext = ALL_ONES;
    else             maskNext = COL_W'(lenMask(lenCode));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg <= '0;
      cntReg   <= '0;
      maskReg  <= '0;
      ilvReg   <= 1'b0;
      fpReg    <= 1'b0;
    end else if (strobes.load) begin
      startReg <= startCol;
      cntReg   <= '0;
      maskReg  <= maskNext;
      ilvReg   <= modeWord[TYPE_BIT];
      fpReg    <= fpNext;
    end else if (strobes.step) begin
      cntReg <= cntReg + 1'b1;
    end
  end

  always_comb begin
    lowSeq = startReg + cntReg;
    lowIlv = startReg ^ cntReg;
    lowSel = (ilvReg && !fpReg) ? lowIlv : lowSeq;
    col    = (startReg & ~maskReg) | (lowSel & maskReg);
  end

  assign atEnd    = (cntReg == maskReg);
  assign fullPage = fpReg;
endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        advance,
  input  logic        stop,
  input  logic        atEnd,
  input  logic        fullPage,
  output colStrobes_t strobes,
  output logic        busy,
  output logic        lastBeat
);
  logic busyReg;

  assign lastBeat = busyReg && atEnd && !fullPage;
  assign busy     = busyReg;

  always_comb begin
    strobes.load = start;
    strobes.step = busyReg && advance && !lastBeat && !start && !stop;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    busyReg <= 1'b0;
    else if (start)               busyReg <= 1'b1;
    else if (stop)                busyReg <= 1'b0;
    else if (advance && lastBeat) busyReg <= 1'b0;
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeWord,
  input  logic [COL_W-1:0]  startCol,
  input  logic              isWrite,
  input  logic              start,
  input  logic              advance,
  input  logic              stop,
  output logic [COL_W-1:0]  col,
  output logic              lastBeat,
  output logic              busy
);
  colStrobes_t strobes;
  logic        atEnd, fullPage;

  burst_col_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .advance(advance), .stop(stop),
    .atEnd(atEnd), .fullPage(fullPage), .strobes(strobes), .busy(busy),
    .lastBeat(lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeWord(modeWord),
    .startCol(startCol), .isWrite(isWrite), .col(col), .atEnd(atEnd),
    .fullPage(fullPage)
  );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeWord,
  input logic [COL_W-1:0]  startCol,
  input logic              isWrite,
  input logic              start,
  input logic              advance,
  input logic              stop,
  input logic [COL_W-1:0]  col,
  input logic              lastBeat,
  input logic              busy
);
  // R7
  last_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> busy);

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && col == $past(startCol)));

  // R6
  hold_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !advance && !start && !stop) |=> ($stable(col) && busy));

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && advance && !start && !stop) |=> !busy);

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stop && !start) |=> !busy);

  // R7
  mid_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastBeat && !start && !stop) |=> busy);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] modeWord = '0;
  logic [7:0]  startCol = '0;
  logic        isWrite = 1'b0;
  logic        start = 1'b0;
  logic        advance = 1'b0;
  logic        stop = 1'b0;
  logic [7:0]  col;
  logic        lastBeat, busy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rstN(rstN), .modeWord(modeWord), .startCol(startCol),
    .isWrite(isWrite), .start(start), .advance(advance), .stop(stop),
    .col(col), .lastBeat(lastBeat), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCol(input int s, input int k, input int len, input bit ilv);
    int m = len - 1;
    int low = ilv ? (s ^ k) : (s + k);
    return (s & ~m & 255) | (low & m);
  endfunction

  // Launch a burst; returns at the negedge where beat 0 is visible
  task automatic launch(input logic [11:0] mw, input int s, input bit wr);
    @(negedge clk);
    modeWord = mw; startCol = 8'(s); isWrite = wr; start = 1'b1; advance = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runFinite(input logic [11:0] mw, input int s, input bit wr,
                           input int len, input bit ilv, input string req);
    launch(mw, s, wr);
    for (int k = 0; k < len; k++) begin
      chk(col == 8'(expCol(s, k, len, ilv)), req, col, expCol(s, k, len, ilv));
      chk(busy == 1'b1, {req, " busy"}, busy, 1);
      chk(lastBeat == (k == len - 1), {req, " R7 last"}, lastBeat, k == len - 1);
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    chk(busy == 1'b0, {req, " R7 end"}, busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(lastBeat == 1'b0, "R1 last", lastBeat, 0);
    rstN = 1'b1;

    // R3 R4 R5 sweep
    for (int code = 0; code < 4; code++) begin
      for (int ty = 0; ty < 2; ty++) begin
        for (int s = 0; s < 256; s++) begin
          runFinite(12'(code | (ty << 3)), s, 1'b0, 1 << code, ty[0],
                    ty ? "R5 ilv" : "R4 seq");
        end
      end
    end

    // R3 reserved codes and ignored upper bits
    for (int code = 4; code < 7; code++)
      runFinite(12'(code), 37, 1'b0, 1, 1'b0, "R3 reserved");
    runFinite(12'hDF3, 13, 1'b0, 8, 1'b0, "R3 ignored bits");

    // R10 single write
    runFinite(12'h203, 21, 1'b1, 1, 1'b0, "R10 write single");
    runFinite(12'h203, 21, 1'b0, 8, 1'b0, "R10 read full");
    runFinite(12'h003, 21, 1'b1, 8, 1'b0, "R10 write no option");
    runFinite(12'h20F, 99, 1'b1, 1, 1'b1, "R10 write fullpage");

    // R8 full page with interleave bit set
    launch(12'h00F, 250, 1'b0);
    for (int k = 0; k < 300; k++) begin
      chk(col == 8'((250 + k) % 256), "R8 col", col, (250 + k) % 256);
      chk(lastBeat == 1'b0, "R8 last", lastBeat, 0);
      chk(busy == 1'b1, "R8 busy", busy, 1);
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0, "R9 stop fullpage", busy, 0);

    // R6 stall mid burst
    launch(12'h002, 6, 1'b0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(col == 8'd7, "R6 stall", col, 7);
    end

    // R9 stop in a finite burst
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(busy == 1'b0, "R9 stop finite", busy, 0);

    // R2 restart while busy, start wins over stop
    launch(12'h003, 40, 1'b0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    modeWord = 12'h001; startCol = 8'd77; start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk(col == 8'd77, "R2 restart col", col, 77);
    chk(busy == 1'b1, "R9 start wins", busy, 1);
    chk(lastBeat == 1'b0, "R2 restart len", lastBeat, 0);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    chk(col == 8'd76, "R2 restart beat1", col, 76);
    chk(lastBeat == 1'b1, "R2 restart last", lastBeat, 1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule